// File: doc/BRIEF.md
# Watchdog overflow reset controller

This block sits next to a watchdog counter and turns the counter's overflow pulse into reset actions and a visible status. It holds one 8-bit control/status byte: an overflow flag, a reset-enable bit and a reset-select bit, with the five low bits fixed at one. When the counter overflows in watchdog mode, the flag is set. If reset enable is 1, a chip-wide reset request is raised for four clock cycles. If it is 0, only a one-cycle local reset is sent back to the counter and its control register. In interval timer mode an overflow sets nothing and resets nothing.

The byte is not touched by the chip reset that the block itself requests. Only the power-on reset or an active standby indication returns it to 0x1F. Software therefore still sees the flag after the watchdog has reset the chip. The flag can be cleared only by a read that sees it at 1, followed by a write with bit 7 at 0. The flag logic is a three-state machine: FL_CLEAR (flag 0), FL_SET (flag 1, not armed) and FL_ARMED (flag 1, a read has been seen).

Flag transitions:
- trip: FL_CLEAR to FL_SET on a watchdog-mode overflow.
- arm: FL_SET to FL_ARMED on a read with no write.
- disarm: FL_SET or FL_ARMED to FL_SET on a write that does not clear the flag.
- clear: FL_ARMED to FL_CLEAR on a write with bit 7 at 0 and no overflow in the same cycle.
- standby: any state to FL_CLEAR.

The reset sequencer is a second machine with the states RS_IDLE, RS_LOCAL and RS_CHIP.
- local-trip: RS_IDLE or RS_LOCAL to RS_LOCAL on a watchdog-mode overflow with reset enable at 0.
- chip-trip: RS_IDLE or RS_LOCAL to RS_CHIP on a watchdog-mode overflow with reset enable at 1.
- expire: RS_CHIP to RS_IDLE after four cycles.
- settle: RS_LOCAL to RS_IDLE after one cycle with no overflow.

Top module: `wdg_rst_ctrl`

## Requirements
- R1: While power-on reset is low, and after it is released, the byte reads 0x1F and neither reset output is high.
- R2: Bits 4 to 0 of the read byte are always 1, whatever was written.
- R3: An overflow pulse in watchdog mode (wd_mode_i=1), outside standby, makes bit 7 read 1 from the next cycle on.
- R4: An overflow pulse in interval mode (wd_mode_i=0) leaves bit 7 unchanged and raises neither reset output, whatever the reset-enable value.
- R5: Bit 7 goes from 1 to 0 only on a write with bit 7 at 0 that follows a read made while bit 7 was 1, with no write in between. A zero-write without that read, or a write with bit 7 at 1, leaves the flag at 1.
- R6: A watchdog-mode overflow in the same cycle as a clearing write keeps bit 7 at 1.
- R7: With bit 6 (reset enable) at 1, a watchdog-mode overflow raises chip_rst_req_o from the next cycle for exactly 4 consecutive cycles. cnt_rst_o is high in the first of those cycles only.
- R8: With bit 6 at 0, a watchdog-mode overflow raises cnt_rst_o for one cycle, starting in the next cycle, and chip_rst_req_o stays low.
- R9: After a chip reset request ends, the byte still holds its flag and its reset-enable value.
- R10: A cycle with standby_i high makes the byte read 0x1F from the next cycle. An overflow during standby sets no flag and raises no reset output.
- R11: Bits 6 and 5 take the written values on every write, whether or not that write clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| standby_i | input | 1 | Standby mode active; forces the byte to 0x1F |
| wd_mode_i | input | 1 | 1 = watchdog mode, 0 = interval timer mode |
| ovf_pulse_i | input | 1 | One-cycle overflow pulse from the counter |
| reg_rd_i | input | 1 | Read strobe for the status byte |
| reg_wr_i | input | 1 | Write strobe for the status byte |
| reg_wdata_i | input | 3 | Write data for bits 7 to 5 of the byte |
| reg_rdata_o | output | 8 | Current value of the status byte |
| chip_rst_req_o | output | 1 | Chip-wide reset request, 4-cycle pulse |
| cnt_rst_o | output | 1 | One-cycle reset for the counter and its control register |

## Verification
Overflow is applied in both modes, with reset enable at 1 and at 0. Interval-mode pulses must change nothing, and the two watchdog cases are told apart by which reset output rises and for how long. The flag clear is tried with a zero-write that had no read before it, a one-write after a read, a proper read then zero-write, and a read then zero-write with a coincident overflow. Each of these separates the armed state from the plain set state and checks the overflow priority. Standby with a pending overflow and a mid-run power-on reset check that only those two sources reinitialize the byte, while the chip reset pulse does not.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    // flag-side state machine
    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    // reset sequencer state machine
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_LOCAL = 2'd1,
        RS_CHIP  = 2'd2
    } rst_state_e;

    localparam int          BYTE_W   = 8;
    localparam int          RO_W     = 5;
    localparam logic [4:0]  RO_FILL  = 5'h1F;
    localparam logic        ENA_INIT = 1'b0;
    localparam logic        SEL_INIT = 1'b0;

endpackage

// File: rtl/wdr_flag_fsm.sv
module wdr_flag_fsm
    import wdr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic standby_i,
    input  logic trip_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_flag_i,
    output logic flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (standby_i) begin
            state_d = FL_CLEAR;
        end else begin
            unique case (state_q)
                FL_CLEAR: begin
                    if (trip_i) begin
                        state_d = FL_SET;
                    end
                end
                FL_SET: begin
                    if (wr_i) begin
                        state_d = FL_SET;
                    end else if (rd_i) begin
                        state_d = FL_ARMED;
                    end
                end
                FL_ARMED: begin
                    if (wr_i) begin
                        if (trip_i || wr_flag_i) begin
                            state_d = FL_SET;
                        end else begin
                            state_d = FL_CLEAR;
                        end
                    end
                end
                default: state_d = FL_CLEAR;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FL_CLEAR: flag_o = 1'b0;
            FL_SET:   flag_o = 1'b1;
            FL_ARMED: flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdr_ctrl_bits.sv
module wdr_ctrl_bits
    import wdr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic standby_i,
    input  logic wr_i,
    input  logic wr_ena_i,
    input  logic wr_sel_i,
    output logic ena_o,
    output logic sel_o
);

    logic ena_q;
    logic sel_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ena_q <= ENA_INIT;
            sel_q <= SEL_INIT;
        end else if (standby_i) begin
            ena_q <= ENA_INIT;
            sel_q <= SEL_INIT;
        end else if (wr_i) begin
            ena_q <= wr_ena_i;
            sel_q <= wr_sel_i;
        end
    end

    assign ena_o = ena_q;
    assign sel_o = sel_q;

endmodule

// File: rtl/wdr_rst_seq.sv
module wdr_rst_seq
    import wdr_pkg::*;
#(
    parameter int CHIP_RST_LEN = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic trip_i,
    input  logic ena_i,
    output logic chip_rst_o,
    output logic cnt_rst_o
);

    localparam int CNT_W = (CHIP_RST_LEN > 1) ? $clog2(CHIP_RST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIP_RST_LEN - 1);

    rst_state_e       state_q;
    rst_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            RS_IDLE, RS_LOCAL: begin
                if (trip_i) begin
                    state_d = ena_i ? RS_CHIP : RS_LOCAL;
                end else begin
                    state_d = RS_IDLE;
                end
            end
            RS_CHIP: begin
                if (cnt_q == LAST) begin
                    state_d = RS_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        chip_rst_o = 1'b0;
        cnt_rst_o  = 1'b0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_LOCAL: cnt_rst_o = 1'b1;
            RS_CHIP: begin
                chip_rst_o = 1'b1;
                cnt_rst_o  = (cnt_q == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wdg_rst_ctrl.sv
module wdg_rst_ctrl
    import wdr_pkg::*;
#(
    parameter int CHIP_RST_LEN = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       standby_i,
    input  logic       wd_mode_i,
    input  logic       ovf_pulse_i,
    input  logic       reg_rd_i,
    input  logic       reg_wr_i,
    input  logic [7:5] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       chip_rst_req_o,
    output logic       cnt_rst_o
);

    logic trip;
    logic flag;
    logic ena;
    logic sel;

    // only a watchdog-mode overflow outside standby counts
    assign trip = ovf_pulse_i && wd_mode_i && !standby_i;

    wdr_flag_fsm u_flag (
        .clk       (clk),
        .por_n     (por_n),
        .standby_i (standby_i),
        .trip_i    (trip),
        .rd_i      (reg_rd_i),
        .wr_i      (reg_wr_i),
        .wr_flag_i (reg_wdata_i[7]),
        .flag_o    (flag)
    );

    wdr_ctrl_bits u_bits (
        .clk       (clk),
        .por_n     (por_n),
        .standby_i (standby_i),
        .wr_i      (reg_wr_i),
        .wr_ena_i  (reg_wdata_i[6]),
        .wr_sel_i  (reg_wdata_i[5]),
        .ena_o     (ena),
        .sel_o     (sel)
    );

    wdr_rst_seq #(
        .CHIP_RST_LEN (CHIP_RST_LEN)
    ) u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .trip_i     (trip),
        .ena_i      (ena),
        .chip_rst_o (chip_rst_req_o),
        .cnt_rst_o  (cnt_rst_o)
    );

    assign reg_rdata_o = {flag, ena, sel, RO_FILL};

endmodule

// File: rtl/wdr_chk.sv
module wdr_chk #(
    parameter int CHIP_RST_LEN = 4
) (
    input logic       clk,
    input logic       por_n,
    input logic       standby_i,
    input logic       wd_mode_i,
    input logic       ovf_pulse_i,
    input logic       reg_wr_i,
    input logic       wdata_msb,
    input logic [7:0] reg_rdata_o,
    input logic       chip_rst_req_o,
    input logic       cnt_rst_o
);

    int unsigned run_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_len <= 0;
        end else begin
            run_len <= chip_rst_req_o ? run_len + 1 : 0;
        end
    end

    assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!por_n)
        (ovf_pulse_i && wd_mode_i && !standby_i) |=> reg_rdata_o[7]);

    assert_intvl_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!(ovf_pulse_i && wd_mode_i) && !reg_rdata_o[7]) |=> !reg_rdata_o[7]);

    assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(reg_rdata_o[7]) |-> ($past(reg_wr_i && !wdata_msb) || $past(standby_i)));

    assert_chip_len_R7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(chip_rst_req_o) |-> (run_len == CHIP_RST_LEN));

    assert_chip_starts_local_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chip_rst_req_o) |-> cnt_rst_o);

    assert_local_only_R8: assert property (@(posedge clk) disable iff (!por_n)
        (ovf_pulse_i && wd_mode_i && !standby_i && !reg_rdata_o[6] && !chip_rst_req_o)
        |=> (cnt_rst_o && !chip_rst_req_o));

    assert_standby_init_R10: assert property (@(posedge clk) disable iff (!por_n)
        standby_i |=> (reg_rdata_o == 8'h1F));

endmodule

bind wdg_rst_ctrl wdr_chk #(
    .CHIP_RST_LEN (CHIP_RST_LEN)
) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .standby_i      (standby_i),
    .wd_mode_i      (wd_mode_i),
    .ovf_pulse_i    (ovf_pulse_i),
    .reg_wr_i       (reg_wr_i),
    .wdata_msb      (reg_wdata_i[7]),
    .reg_rdata_o    (reg_rdata_o),
    .chip_rst_req_o (chip_rst_req_o),
    .cnt_rst_o      (cnt_rst_o)
);

// File: tb/sim_wdg_rst_ctrl.sv
`timescale 1ns/1ps
module sim_wdg_rst_ctrl;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       standby_i = 1'b0;
    logic       wd_mode_i = 1'b1;
    logic       ovf_pulse_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:5] reg_wdata_i = 3'b000;
    logic [7:0] reg_rdata_o;
    logic       chip_rst_req_o;
    logic       cnt_rst_o;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    wdg_rst_ctrl u0 (
        .clk            (clk),
        .por_n          (por_n),
        .standby_i      (standby_i),
        .wd_mode_i      (wd_mode_i),
        .ovf_pulse_i    (ovf_pulse_i),
        .reg_rd_i       (reg_rd_i),
        .reg_wr_i       (reg_wr_i),
        .reg_wdata_i    (reg_wdata_i),
        .reg_rdata_o    (reg_rdata_o),
        .chip_rst_req_o (chip_rst_req_o),
        .cnt_rst_o      (cnt_rst_o)
    );

    // {rd, wr, wdata[7:5], ovf, wd_mode, exp_rdata, exp_chip, exp_cnt}
    localparam int NV = 22;
    localparam logic [16:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0}, // 0  R1 idle
        {1'b0, 1'b1, 3'b011, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b0}, // 1  R11 ena+sel
        {1'b0, 1'b1, 3'b010, 1'b0, 1'b1, 8'h5F, 1'b0, 1'b0}, // 2  R11 ena only
        {1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 8'h5F, 1'b0, 1'b0}, // 3  R4 interval ovf
        {1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 8'hDF, 1'b1, 1'b1}, // 4  R3/R7 wd ovf
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'hDF, 1'b1, 1'b0}, // 5  R7
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'hDF, 1'b1, 1'b0}, // 6  R7
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'hDF, 1'b1, 1'b0}, // 7  R7
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'hDF, 1'b0, 1'b0}, // 8  R9 survives
        {1'b0, 1'b1, 3'b010, 1'b0, 1'b1, 8'hDF, 1'b0, 1'b0}, // 9  R5 no read
        {1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 8'hDF, 1'b0, 1'b0}, // 10 R5 read
        {1'b0, 1'b1, 3'b110, 1'b0, 1'b1, 8'hDF, 1'b0, 1'b0}, // 11 R5 write one
        {1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 8'hDF, 1'b0, 1'b0}, // 12 R5 read
        {1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0}, // 13 R5 clear, R2
        {1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 8'h9F, 1'b0, 1'b1}, // 14 R8 local only
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'h9F, 1'b0, 1'b0}, // 15 R8 one cycle
        {1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 8'h9F, 1'b0, 1'b0}, // 16 R6 read
        {1'b0, 1'b1, 3'b000, 1'b1, 1'b1, 8'h9F, 1'b0, 1'b1}, // 17 R6 clear+ovf
        {1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 8'h9F, 1'b0, 1'b0}, // 18 R6
        {1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 8'h9F, 1'b0, 1'b0}, // 19 R5 read
        {1'b0, 1'b1, 3'b001, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0}, // 20 R11 clear+sel
        {1'b0, 1'b1, 3'b111, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b0}  // 21 R2/R5 write ones
    };

    function automatic string vec_tag(int i);
        case (i)
            0:                   return "R1";
            1, 2, 20:            return "R11";
            3:                   return "R4";
            4, 5, 6, 7:          return "R7";
            8:                   return "R9";
            9, 10, 11, 12, 19:   return "R5";
            13, 21:              return "R2";
            14, 15:              return "R8";
            default:             return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_rd_i    = 1'b0;
        reg_wr_i    = 1'b0;
        reg_wdata_i = 3'b000;
        ovf_pulse_i = 1'b0;
        wd_mode_i   = 1'b1;
    endtask

    initial begin
        #40000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in power-on reset
        check("R1", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});
        por_n = 1'b1;
        @(negedge clk);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            {reg_rd_i, reg_wr_i, reg_wdata_i, ovf_pulse_i, wd_mode_i} = VEC[i][16:10];
            @(negedge clk);
            check(vec_tag(i), {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, VEC[i][9:0]);
        end
        idle_inputs();
        @(negedge clk);

        // R4: interval overflow with reset enable 0, no local reset either
        reg_wr_i = 1'b1; reg_wdata_i = 3'b000;
        @(negedge clk);
        idle_inputs();
        ovf_pulse_i = 1'b1; wd_mode_i = 1'b0;
        @(negedge clk);
        check("R4", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});
        idle_inputs();

        // R9: chip reset with ena+sel, byte kept afterwards
        reg_wr_i = 1'b1; reg_wdata_i = 3'b011;
        @(negedge clk);
        idle_inputs();
        ovf_pulse_i = 1'b1;
        @(negedge clk);
        idle_inputs();
        repeat (4) @(negedge clk);
        check("R9", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'hFF, 2'b00});

        // R10: standby reinitializes, overflow inside standby ignored
        standby_i = 1'b1;
        @(negedge clk);
        check("R10", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});
        reg_wr_i = 1'b1; reg_wdata_i = 3'b010;
        @(negedge clk);
        idle_inputs();
        ovf_pulse_i = 1'b1;
        @(negedge clk);
        check("R10", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});
        idle_inputs();
        standby_i = 1'b0;
        @(negedge clk);
        check("R10", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});

        // R1: power-on reset in the middle of a chip reset pulse
        reg_wr_i = 1'b1; reg_wdata_i = 3'b011;
        @(negedge clk);
        idle_inputs();
        ovf_pulse_i = 1'b1;
        @(negedge clk);
        idle_inputs();
        por_n = 1'b0;
        #1;
        check("R1", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1", {reg_rdata_o, chip_rst_req_o, cnt_rst_o}, {8'h1F, 2'b00});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule